// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, and passes data between them in whichever direction the control inputs pick. Each direction owns a storage register with its own capture strobe. A per-direction select chooses what the driven side shows: the live value on the far bus, or the value that direction's register captured last. A global output disable puts both sides into input-only mode. Capture still works while both sides are inputs, so the block can sample both buses while driving nothing.

Each bus appears as three vectors: a receive vector, a transmit vector and a per-bit drive enable. This keeps the block free of internal tri-states, and a pad ring can add the real buffers later. The two capture strobes are ordinary inputs in the system clock domain. The block samples them each cycle and acts on a low-to-high change. A parameter sets the data width, and another can invert the transmit data.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While `oe_n` is 1, every bit of `a_oe` and `b_oe` is 0, whatever the direction, strobe and select inputs are.
- R2: While `oe_n` is 0 and `dir` is 0, every bit of `a_oe` is 1 and every bit of `b_oe` is 0.
- R3: While `oe_n` is 0 and `dir` is 1, every bit of `b_oe` is 1 and every bit of `a_oe` is 0.
- R4: While A is driven and `sel_ba` is 0, `a_out` equals `b_in` in the same cycle. With `INVERT_OUT` = 0 the data is not inverted.
- R5: While B is driven and `sel_ab` is 0, `b_out` equals `a_in` in the same cycle.
- R6: At a clock edge where `stb_ba` is sampled 1 and was sampled 0 at the edge before, the B-to-A register loads `b_in`. While A is driven with `sel_ba` at 1, `a_out` shows that register from the cycle after the edge.
- R7: At a clock edge where `stb_ab` is sampled 1 and was sampled 0 at the edge before, the A-to-B register loads `a_in`. While B is driven with `sel_ab` at 1, `b_out` shows that register from the cycle after the edge.
- R8: A strobe that stays 1 or falls to 0 loads nothing. Only a low-to-high change captures.
- R9: Captures take place while `oe_n` is 1, and the value captured is shown once the outputs are enabled.
- R10: A synchronous reset, `rst` at 1 on a clock edge, clears both registers to zero. It also clears both strobe history bits to 0, so a strobe that is held at 1 through the reset captures on the first edge after the reset is released.
- R11: The drive enables of A and B are never both active, and neither a strobe nor a select changes which bus is driven.
- R12: A transmit vector reads all zeros whenever its drive enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output disable: 1 makes both buses inputs |
| dir | input | 1 | 0 drives bus A, 1 drives bus B |
| stb_ab | input | 1 | Capture strobe for the A-to-B register |
| stb_ba | input | 1 | Capture strobe for the B-to-A register |
| sel_ab | input | 1 | 0 sends live A data to B, 1 sends the A-to-B register |
| sel_ba | input | 1 | 0 sends live B data to A, 1 sends the B-to-A register |
| a_in | input | WIDTH | Value received on bus A |
| a_out | output | WIDTH | Value transmitted on bus A |
| a_oe | output | WIDTH | Per-bit drive enable for bus A |
| b_in | input | WIDTH | Value received on bus B |
| b_out | output | WIDTH | Value transmitted on bus B |
| b_oe | output | WIDTH | Per-bit drive enable for bus B |

## Verification
The drive enables and live pass-through data are combinational, so they are due in the same cycle the stimulus is applied. Stored data is due one cycle after the edge that saw the strobe rise, because one register lies between the strobe and the output. The bench applies each vector at the falling edge and lets one rising edge pass. It then samples two nanoseconds later, which places the sample after any capture that edge made and before the next vector is applied. The expected stored values in the vector table follow the strobe history across steps, including the held-high strobe after reset.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

   typedef enum logic [1:0] {
      DRV_NONE = 2'b00,
      DRV_A    = 2'b01,
      DRV_B    = 2'b10
   } drv_mode_e;

endpackage

// File: rtl/bxr_edge_cap.sv
module bxr_edge_cap #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             stb_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic stb_seen;
   logic fire;

   assign fire = stb_i & ~stb_seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         stb_seen <= 1'b0;
         q_o      <= '0;
      end else begin
         stb_seen <= stb_i;
         if (fire) q_o <= d_i;
      end
   end

   // R6 / R7: a rising strobe loads the data present at that edge
   assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
      fire |=> (q_o == $past(d_i)));

   // R8: no rising strobe, no change
   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !fire |=> (q_o == $past(q_o)));

   // R10: reset clears the stored word
   assert_reset_clear_R10: assert property (@(posedge clk)
      rst |=> (q_o == '0));

endmodule

// File: rtl/bxr_dir_ctrl.sv
module bxr_dir_ctrl
   import bxr_pkg::*;
(
   input  logic      oe_n,
   input  logic      dir,
   output drv_mode_e mode_o
);

   always_comb begin
      if (oe_n)     mode_o = DRV_NONE;
      else if (dir) mode_o = DRV_B;
      else          mode_o = DRV_A;
   end

endmodule

// File: rtl/bxr_out_path.sv
module bxr_out_path #(
   parameter int WIDTH      = 8,
   parameter bit INVERT_OUT = 1'b0
) (
   input  logic             en_i,
   input  logic             sel_i,
   input  logic [WIDTH-1:0] live_i,
   input  logic [WIDTH-1:0] held_i,
   output logic [WIDTH-1:0] out_o
);

   logic [WIDTH-1:0] pick;
   logic [WIDTH-1:0] pol;

   assign pick = sel_i ? held_i : live_i;

   generate
      if (INVERT_OUT) begin : g_inv
         assign pol = ~pick;
      end else begin : g_true
         assign pol = pick;
      end
   endgenerate

   assign out_o = en_i ? pol : '0;

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
   import bxr_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit INVERT_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             oe_n,
   input  logic             dir,
   input  logic             stb_ab,
   input  logic             stb_ba,
   input  logic             sel_ab,
   input  logic             sel_ba,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe
);

   localparam logic [WIDTH-1:0] INV_MASK = INVERT_OUT ? {WIDTH{1'b1}} : '0;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("bus_xcvr_reg: WIDTH must be at least 1");
      end
   endgenerate

   drv_mode_e        mode;
   logic             drive_a;
   logic             drive_b;
   logic [WIDTH-1:0] held_ab;
   logic [WIDTH-1:0] held_ba;

   bxr_dir_ctrl u_dir (
      .oe_n   (oe_n),
      .dir    (dir),
      .mode_o (mode)
   );

   assign drive_a = (mode == DRV_A);
   assign drive_b = (mode == DRV_B);
   assign a_oe    = {WIDTH{drive_a}};
   assign b_oe    = {WIDTH{drive_b}};

   bxr_edge_cap #(.WIDTH(WIDTH)) u_cap_ab (
      .clk   (clk),
      .rst   (rst),
      .stb_i (stb_ab),
      .d_i   (a_in),
      .q_o   (held_ab)
   );

   bxr_edge_cap #(.WIDTH(WIDTH)) u_cap_ba (
      .clk   (clk),
      .rst   (rst),
      .stb_i (stb_ba),
      .d_i   (b_in),
      .q_o   (held_ba)
   );

   bxr_out_path #(.WIDTH(WIDTH), .INVERT_OUT(INVERT_OUT)) u_out_a (
      .en_i   (drive_a),
      .sel_i  (sel_ba),
      .live_i (b_in),
      .held_i (held_ba),
      .out_o  (a_out)
   );

   bxr_out_path #(.WIDTH(WIDTH), .INVERT_OUT(INVERT_OUT)) u_out_b (
      .en_i   (drive_b),
      .sel_i  (sel_ab),
      .live_i (a_in),
      .held_i (held_ab),
      .out_o  (b_out)
   );

   assert_all_off_R1: assert property (@(posedge clk) disable iff (rst)
      oe_n |-> (a_oe == '0 && b_oe == '0));

   assert_drive_a_R2: assert property (@(posedge clk) disable iff (rst)
      (!oe_n && !dir) |-> (&a_oe && b_oe == '0));

   assert_drive_b_R3: assert property (@(posedge clk) disable iff (rst)
      (!oe_n && dir) |-> (&b_oe && a_oe == '0));

   assert_live_a_R4: assert property (@(posedge clk) disable iff (rst)
      (!oe_n && !dir && !sel_ba) |-> (a_out == (b_in ^ INV_MASK)));

   assert_live_b_R5: assert property (@(posedge clk) disable iff (rst)
      (!oe_n && dir && !sel_ab) |-> (b_out == (a_in ^ INV_MASK)));

   assert_oe_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
      !((|a_oe) && (|b_oe)));

   assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
      ((a_oe == '0) |-> (a_out == '0)) and ((b_oe == '0) |-> (b_out == '0)));

endmodule

// File: tb/bus_xcvr_reg_tb_top.sv
module bus_xcvr_reg_tb_top;

   localparam int W = 8;

   typedef struct packed {
      logic       rst, oen, dir, sab_stb, sba_stb, sab, sba;
      logic [7:0] a, b;
      logic       eao, ebo;
      logic [7:0] ea, eb;
      logic [7:0] req;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h11,8'h22,1'b0,1'b0,8'h00,8'h00,8'd10}, // R10 reset
      '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'h3C,8'hA5,1'b0,1'b0,8'h00,8'h00,8'd9},  // R9 capture while off
      '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,8'hFF,8'h0F,1'b1,1'b0,8'hA5,8'h00,8'd8},  // R8 held strobe
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h5A,1'b1,1'b0,8'h5A,8'h00,8'd4},  // R4 live B->A
      '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'h77,8'h12,1'b0,1'b1,8'h00,8'h3C,8'd12}, // R12 / R7
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,8'hC3,8'h12,1'b0,1'b1,8'h00,8'hC3,8'd7},  // R7 registered pass
      '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h81,8'h12,1'b0,1'b1,8'h00,8'h81,8'd5},  // R5 live A->B
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h81,8'hE7,1'b1,1'b0,8'hE7,8'h00,8'd6},  // R6 registered pass
      '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,8'h44,8'h99,1'b0,1'b0,8'h00,8'h00,8'd1},  // R1 off
      '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,8'h10,8'h66,1'b0,1'b1,8'h00,8'h44,8'd3},  // R3
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h10,8'h01,1'b1,1'b0,8'h66,8'h00,8'd2},  // R2
      '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h10,8'hFF,1'b1,1'b0,8'h00,8'h00,8'd10}, // R10 mid-run reset
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h10,8'h3E,1'b1,1'b0,8'h3E,8'h00,8'd10}  // R10 held strobe fires
   };

   logic         clk = 1'b0;
   logic         rst, oe_n, dir, stb_ab, stb_ba, sel_ab, sel_ba;
   logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;
   int           checks = 0;
   int           errors = 0;
   bit           done   = 1'b0;

   always #5 clk = ~clk;

   bus_xcvr_reg #(.WIDTH(W), .INVERT_OUT(1'b0)) dut_i (
      .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
      .stb_ab(stb_ab), .stb_ba(stb_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      rst = 1'b1; oe_n = 1'b1; dir = 1'b0; stb_ab = 1'b0; stb_ba = 1'b0;
      sel_ab = 1'b0; sel_ba = 1'b0; a_in = '0; b_in = '0;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         rst = TBL[i].rst; oe_n = TBL[i].oen; dir = TBL[i].dir;
         stb_ab = TBL[i].sab_stb; stb_ba = TBL[i].sba_stb;
         sel_ab = TBL[i].sab; sel_ba = TBL[i].sba;
         a_in = TBL[i].a; b_in = TBL[i].b;
         @(posedge clk);
         #2;
         check($sformatf("R%0d step %0d a_oe", TBL[i].req, i), a_oe, {W{TBL[i].eao}});
         check($sformatf("R%0d step %0d b_oe", TBL[i].req, i), b_oe, {W{TBL[i].ebo}});
         check($sformatf("R%0d step %0d a_out", TBL[i].req, i), a_out, TBL[i].ea);
         check($sformatf("R%0d step %0d b_out", TBL[i].req, i), b_out, TBL[i].eb);
      end

      // R11: sweep all control combinations; strobes and selects never steer the enables
      for (int c = 0; c < 64; c++) begin
         @(negedge clk);
         {oe_n, dir, stb_ab, stb_ba, sel_ab, sel_ba} = 6'(c);
         #1;
         check("R11 exclusive enables", {7'd0, (|a_oe) & (|b_oe)}, 8'd0);
         check("R11 a_oe from oe_n/dir", a_oe, {W{~oe_n & ~dir}});
         check("R11 b_oe from oe_n/dir", b_oe, {W{~oe_n & dir}});
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule